// File: doc/BRIEF.md
# Dual Timer/Counter Peripheral

This peripheral holds two independent counting channels. Each channel keeps a 16-bit count split into a low byte and a high byte, and each can be pointed at one of two count sources: a shared internal tick that fires once every `DIV` clocks (twelve by default), or falling edges seen on the channel's own count pin. A per-channel gate option lets an external pin hold the channel stopped while the pin is low. Each channel has a run bit and a sticky overflow flag.

A four-bit configuration nibble per channel picks the count width. There is a 13-bit form, in which a 5-bit prescaler inside the low byte carries into the high byte. There is a plain 16-bit form. There is an 8-bit form in which the low byte reloads from the high byte after it wraps. There is also a split form for channel 0, in which its two bytes run as separate 8-bit counters. Software uses a small byte-wide register bus with a one-cycle read latency to set up the configuration, start and stop the channels, read and clear the flags, and load or sample the four count bytes.

Top module: `tmr_pair`

## Requirements
- R1: After a synchronous reset, every register reads 0x00: the configuration byte, the control byte and all four count bytes. The divider phase also returns to zero.
- R2: Bus map: address 0 is the configuration byte, 1 the control byte, 2 and 3 the channel 0 low and high bytes, and 4 and 5 the channel 1 low and high bytes. `bus_rdata` presents the addressed register one clock after the address is applied. Addresses 6 and 7 read 0x00 and ignore writes. Control bits 3..0 always read 0.
- R3: Configuration nibble {gate, ext, m1, m0}: channel 1 uses bits 7..4 and channel 0 uses bits 3..0. With mode 00, the low 5 bits of the low byte and the high byte form a 13-bit counter, and low-byte bits 7..5 are left untouched. The overflow comes when the count wraps from 0x1FFF to 0.
- R4: With mode 01, {high, low} counts as one 16-bit value and overflows when it wraps from 0xFFFF to 0.
- R5: With mode 10, only the low byte counts. On a step from 0xFF it loads the high byte's value and signals an overflow. The high byte itself never changes, except through a bus write.
- R6: With ext=0, a channel steps once per internal tick, which is one clock in every `DIV`. With ext=1, it steps on 1-to-0 transitions of its count pin, after a two-flop synchroniser, and takes at most one step per tick period. Internal ticks do not step it.
- R7: A channel steps only while its run bit is set. If its gate bit is set, its gate pin must also be high.
- R8: Control byte layout: bit 7 is the channel 1 flag, bit 6 the channel 1 run bit, bit 5 the channel 0 flag and bit 4 the channel 0 run bit. An overflow sets the flag, and the flag stays set until a control write clears it. If a set and a write fall in the same cycle, the set wins.
- R9: With channel 0 in mode 11, its low byte is an 8-bit counter that uses channel 0's run, gate and source and sets flag 0. Its high byte is an 8-bit timer on internal ticks that uses run bit 1 and sets flag 1.
- R10: A bus write to any count byte of a channel cancels that channel's step in the same cycle. The written value is kept exactly.
- R11: Channel 1 holds its count while channel 0 is in mode 11, and also while channel 1's own mode is 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, one cycle after the address |
| cnt_pin | input | 2 | External count pins, one per channel |
| gate_pin | input | 2 | Gate pins, one per channel; high lets a gated channel run |

## Verification
The hardest case to reach from the ports is a count-byte write that lands on the exact cycle of an internal tick. The divider phase cannot be seen directly. To reach it, the bench starts channel 0 and holds the read address on the channel 0 low byte. It watches the registered read data until the value changes, which pins the tick edge to a known clock. It then waits the rest of the divider period and issues the write on the next tick edge. Run windows are always a whole number of divider periods long, so every other count is exact whatever the divider phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH    = 2;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    M_W13   = 2'b00,
    M_W16   = 2'b01,
    M_RELD  = 2'b10,
    M_SPLIT = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext;
    tmr_mode_e mode;
  } chan_cfg_t;

  localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] A_C0LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_C0HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_C1LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_C1HI = 3'd5;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int DIV = 12,
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] cnt_pin,
  input  logic [NCH-1:0] gate_pin,
  output logic           tick,
  output logic [NCH-1:0] ext_evt,
  output logic [NCH-1:0] gate_ok
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || pre_q == LAST) pre_q <= '0;
    else                      pre_q <= pre_q + PW'(1);
  end

  assign tick = (pre_q == LAST);

  for (genvar i = 0; i < NCH; i++) begin : g_pin
    logic s1_q, s2_q, s3_q, pend_q, g1_q, g2_q;
    logic fall;

    assign fall = s3_q & ~s2_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        s3_q   <= 1'b0;
        pend_q <= 1'b0;
        g1_q   <= 1'b0;
        g2_q   <= 1'b0;
      end else begin
        s1_q <= cnt_pin[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
        g1_q <= gate_pin[i];
        g2_q <= g1_q;
        if (tick)      pend_q <= 1'b0;
        else if (fall) pend_q <= 1'b1;
      end
    end

    assign ext_evt[i] = tick & (pend_q | fall);
    assign gate_ok[i] = g2_q;
  end
endmodule

// File: rtl/tmr_count_chan.sv
module tmr_count_chan
  import tmr_pkg::*;
#(
  parameter int W  = 8,
  parameter int PW = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  tmr_mode_e    mode,
  input  logic         step_lo,
  input  logic         step_hi,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi,
  output logic         ovf_lo,
  output logic         ovf_hi
);
  localparam int SW = W + PW;

  logic [W-1:0]   lo_d, hi_d;
  logic [SW-1:0]  sum13;
  logic [2*W-1:0] sum16;

  assign sum13 = {hi, lo[PW-1:0]} + SW'(1);
  assign sum16 = {hi, lo} + (2*W)'(1);

  always_comb begin
    lo_d   = lo;
    hi_d   = hi;
    ovf_lo = 1'b0;
    ovf_hi = 1'b0;
    if (wr_lo || wr_hi) begin
      if (wr_lo) lo_d = wdata;
      if (wr_hi) hi_d = wdata;
    end else begin
      unique case (mode)
        M_W13: if (step_lo) begin
          lo_d   = {lo[W-1:PW], sum13[PW-1:0]};
          hi_d   = sum13[SW-1:PW];
          ovf_lo = &{hi, lo[PW-1:0]};
        end
        M_W16: if (step_lo) begin
          {hi_d, lo_d} = sum16;
          ovf_lo       = &{hi, lo};
        end
        M_RELD: if (step_lo) begin
          ovf_lo = &lo;
          lo_d   = (&lo) ? hi : lo + W'(1);
        end
        M_SPLIT: begin
          if (step_lo) begin
            lo_d   = lo + W'(1);
            ovf_lo = &lo;
          end
          if (step_hi) begin
            hi_d   = hi + W'(1);
            ovf_hi = &hi;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= lo_d;
      hi <= hi_d;
    end
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int DIV    = 12,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    cnt_pin,
  input  logic [NCH-1:0]    gate_pin
);
  logic [BYTE_W-1:0] cfg_q;
  logic [NCH-1:0]    run_q, flag_q;
  chan_cfg_t         cfg [NCH];

  logic              tick;
  logic [NCH-1:0]    ext_evt, gate_ok;
  logic [NCH-1:0]    en, src, step_lo, step_hi, wr_lo, wr_hi;
  logic [NCH-1:0]    ovf_lo, ovf_hi, flag_set;
  logic [BYTE_W-1:0] cnt_lo [NCH];
  logic [BYTE_W-1:0] cnt_hi [NCH];
  logic              split0, hold1;

  assign cfg[0] = chan_cfg_t'(cfg_q[3:0]);
  assign cfg[1] = chan_cfg_t'(cfg_q[7:4]);
  assign split0 = (cfg[0].mode == M_SPLIT);
  assign hold1  = split0 || (cfg[1].mode == M_SPLIT);

  tmr_tick_gen #(.DIV(DIV), .NCH(NCH)) i_tick (
    .clk     (clk),
    .rst     (rst),
    .cnt_pin (cnt_pin),
    .gate_pin(gate_pin),
    .tick    (tick),
    .ext_evt (ext_evt),
    .gate_ok (gate_ok)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign en[i]    = run_q[i] && (!cfg[i].gate || gate_ok[i]);
    assign src[i]   = cfg[i].ext ? ext_evt[i] : tick;
    assign wr_lo[i] = bus_wr && (bus_addr == A_C0LO + ADDR_W'(2 * i));
    assign wr_hi[i] = bus_wr && (bus_addr == A_C0HI + ADDR_W'(2 * i));

    if (i == 0) begin : g_c0
      assign step_lo[i] = en[i] & src[i];
      assign step_hi[i] = split0 & run_q[1] & tick;
    end else begin : g_cn
      assign step_lo[i] = en[i] & src[i] & ~hold1;
      assign step_hi[i] = 1'b0;
    end

    tmr_count_chan #(.W(BYTE_W), .PW(PRE_W)) i_chan (
      .clk    (clk),
      .rst    (rst),
      .mode   (cfg[i].mode),
      .step_lo(step_lo[i]),
      .step_hi(step_hi[i]),
      .wr_lo  (wr_lo[i]),
      .wr_hi  (wr_hi[i]),
      .wdata  (bus_wdata),
      .lo     (cnt_lo[i]),
      .hi     (cnt_hi[i]),
      .ovf_lo (ovf_lo[i]),
      .ovf_hi (ovf_hi[i])
    );
  end

  assign flag_set[0] = ovf_lo[0];
  assign flag_set[1] = ovf_lo[1] | ovf_hi[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      if (bus_wr && bus_addr == A_CFG) cfg_q <= bus_wdata;
      if (bus_wr && bus_addr == A_CTRL) begin
        run_q  <= {bus_wdata[6], bus_wdata[4]};
        flag_q <= {bus_wdata[7], bus_wdata[5]} | flag_set;
      end else begin
        flag_q <= flag_q | flag_set;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      unique case (bus_addr)
        A_CFG:   bus_rdata <= cfg_q;
        A_CTRL:  bus_rdata <= {flag_q[1], run_q[1], flag_q[0], run_q[0], 4'b0000};
        A_C0LO:  bus_rdata <= cnt_lo[0];
        A_C0HI:  bus_rdata <= cnt_hi[0];
        A_C1LO:  bus_rdata <= cnt_lo[1];
        A_C1HI:  bus_rdata <= cnt_hi[1];
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_wr,
  input logic [2:0] bus_addr,
  input logic [7:0] bus_rdata,
  input logic [7:0] cfg_q,
  input logic [1:0] run_q,
  input logic [1:0] flag_q,
  input logic [7:0] lo0,
  input logic [7:0] hi0,
  input logic [7:0] lo1,
  input logic       tick
);
  logic wr_ctrl, wr_c0, wr_c0hi, wr_c1;
  assign wr_ctrl = bus_wr && bus_addr == 3'd1;
  assign wr_c0   = bus_wr && (bus_addr == 3'd2 || bus_addr == 3'd3);
  assign wr_c0hi = bus_wr && bus_addr == 3'd3;
  assign wr_c1   = bus_wr && (bus_addr == 3'd4 || bus_addr == 3'd5);

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr > 3'd5) |=> (bus_rdata == 8'h00)); // R2
  AST_RELOAD_HI_FIXED: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[1:0] == 2'b10 && !wr_c0hi) |=> $stable(hi0)); // R5
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R6
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!run_q[0] && cfg_q[1:0] != 2'b11 && !wr_c0) |=> ($stable(lo0) && $stable(hi0))); // R7
  AST_FLAG0_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q[0] && !wr_ctrl) |=> flag_q[0]); // R8
  AST_FLAG1_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q[1] && !wr_ctrl) |=> flag_q[1]); // R8
  AST_CH1_HELD: assert property (@(posedge clk) disable iff (rst)
    ((cfg_q[1:0] == 2'b11 || cfg_q[5:4] == 2'b11) && !wr_c1) |=> $stable(lo1)); // R11
endmodule

bind tmr_pair tmr_pair_chk i_tmr_pair_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .cfg_q    (cfg_q),
  .run_q    (run_q),
  .flag_q   (flag_q),
  .lo0      (cnt_lo[0]),
  .hi0      (cnt_hi[0]),
  .lo1      (cnt_lo[1]),
  .tick     (tick)
);

// File: tb/test_tmr_pair.sv
`timescale 1ns/1ps
module test_tmr_pair;
  localparam int DIV = 12;

  logic       clk = 1'b0;
  logic       rst;
  logic       bus_wr;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [1:0] cnt_pin, gate_pin;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_pair #(.DIV(DIV)) i_tmr_pair (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_pin(cnt_pin), .gate_pin(gate_pin)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  // Run window of exactly n*DIV edges; control is sampled two edges before the end.
  task automatic run_ticks(logic [7:0] cval, int n, output logic [7:0] cap);
    wr(3'd1, cval);
    repeat (n * DIV - 2) @(negedge clk);
    rd(3'd1, cap);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 6; a++) rd_chk("R1 reset value", 3'(a), 8'h00);
  endtask

  task automatic t_bus;
    wr(3'd1, 8'h0F);
    rd_chk("R2 control low nibble", 3'd1, 8'h00);
    wr(3'd7, 8'hAA);
    rd_chk("R2 reserved read", 3'd6, 8'h00);
    rd_chk("R2 reserved read 7", 3'd7, 8'h00);
    rd_chk("R2 reserved write ignored", 3'd2, 8'h00);
    wr(3'd5, 8'h5A);
    rd_chk("R2 byte at address 5", 3'd5, 8'h5A);
    wr(3'd5, 8'h00);
  endtask

  task automatic t_w16;
    logic [7:0] cap;
    wr(3'd0, 8'h01); wr(3'd2, 8'hF0); wr(3'd3, 8'h12);
    run_ticks(8'h10, 20, cap);
    chk("R4 16-bit control", cap, 8'h10);
    rd_chk("R4 R6 16-bit low", 3'd2, 8'h04);
    rd_chk("R4 16-bit high carry", 3'd3, 8'h13);
  endtask

  task automatic t_w13;
    logic [7:0] cap;
    wr(3'd0, 8'h00); wr(3'd2, 8'hFC); wr(3'd3, 8'hFF);
    run_ticks(8'h10, 6, cap);
    chk("R3 13-bit wrap flag", cap, 8'h30);
    rd_chk("R3 13-bit low keeps bits 7..5", 3'd2, 8'hE2);
    rd_chk("R3 13-bit high", 3'd3, 8'h00);
  endtask

  task automatic t_reload;
    logic [7:0] cap;
    wr(3'd0, 8'h02); wr(3'd3, 8'hCE); wr(3'd2, 8'hCE);
    run_ticks(8'h10, 49, cap);
    chk("R5 no overflow before 50 steps", cap, 8'h10);
    rd_chk("R5 low at 0xFF", 3'd2, 8'hFF);
    run_ticks(8'h10, 3, cap);
    chk("R8 flag set and sticky", cap, 8'h30);
    rd_chk("R5 reloaded then stepped", 3'd2, 8'hD0);
    rd_chk("R5 high unchanged", 3'd3, 8'hCE);
    rd_chk("R8 write clears flag", 3'd1, 8'h00);
  endtask

  task automatic t_ext;
    logic [7:0] cap, v;
    wr(3'd0, 8'h05); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    run_ticks(8'h10, 3, cap);
    rd_chk("R6 ext ignores internal ticks", 3'd2, 8'h00);
    fork
      run_ticks(8'h10, 12, cap);
      begin
        repeat (10) @(negedge clk);
        for (int k = 0; k < 5; k++) begin
          cnt_pin[0] = 1'b0; repeat (10) @(negedge clk);
          cnt_pin[0] = 1'b1; repeat (10) @(negedge clk);
        end
      end
    join
    rd_chk("R6 five spaced falling edges", 3'd2, 8'h05);
    wr(3'd2, 8'h00);
    fork
      run_ticks(8'h10, 5, cap);
      begin
        repeat (10) @(negedge clk);
        for (int k = 0; k < 5; k++) begin
          cnt_pin[0] = k[0]; @(negedge clk);
        end
        cnt_pin[0] = 1'b1;
      end
    join
    rd(3'd2, v);
    checks++;
    if (v < 8'd1 || v > 8'd2) begin
      failures++;
      $display("FAIL R6 burst limit actual=0x%02h expected=0x01..0x02", v);
    end
  endtask

  task automatic t_gate;
    logic [7:0] cap;
    wr(3'd0, 8'h90); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    gate_pin[1] = 1'b0; repeat (5) @(negedge clk);
    run_ticks(8'h40, 10, cap);
    rd_chk("R7 gate low holds", 3'd4, 8'h00);
    gate_pin[1] = 1'b1; repeat (5) @(negedge clk);
    run_ticks(8'h40, 10, cap);
    rd_chk("R7 gate high runs", 3'd4, 8'h0A);
    wr(3'd0, 8'h10); wr(3'd4, 8'h00);
    gate_pin[1] = 1'b0; repeat (5) @(negedge clk);
    run_ticks(8'h40, 4, cap);
    rd_chk("R7 ungated ignores pin", 3'd4, 8'h04);
    wr(3'd0, 8'h01); wr(3'd2, 8'h00);
    repeat (3 * DIV) @(negedge clk);
    rd_chk("R7 run clear holds", 3'd2, 8'h00);
  endtask

  task automatic t_split;
    logic [7:0] cap;
    wr(3'd0, 8'h13);
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF); wr(3'd4, 8'h55); wr(3'd5, 8'h00);
    run_ticks(8'h50, 3, cap);
    chk("R9 both flags in split", cap, 8'hF0);
    rd_chk("R9 split low byte", 3'd2, 8'h01);
    rd_chk("R9 split high byte", 3'd3, 8'h02);
    rd_chk("R11 channel 1 held by split", 3'd4, 8'h55);
    wr(3'd0, 8'h31); wr(3'd4, 8'h20);
    run_ticks(8'h40, 4, cap);
    rd_chk("R11 channel 1 own mode 11 holds", 3'd4, 8'h20);
  endtask

  task automatic t_wr_wins;
    logic [7:0] prev;
    bit found = 1'b0;
    wr(3'd0, 8'h01); wr(3'd2, 8'h10); wr(3'd3, 8'h00);
    wr(3'd1, 8'h10);
    bus_addr = 3'd2;
    @(negedge clk);
    prev = bus_rdata;
    for (int k = 0; k < 3 * DIV && !found; k++) begin
      @(negedge clk);
      if (bus_rdata !== prev) found = 1'b1;
    end
    repeat (DIV - 2) @(negedge clk);
    wr(3'd2, 8'h40);
    wr(3'd1, 8'h00);
    chk("R10 tick edge located", {7'd0, found}, 8'h01);
    rd_chk("R10 write wins over step", 3'd2, 8'h40);
    rd_chk("R10 high untouched", 3'd3, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    cnt_pin = 2'b11; gate_pin = 2'b00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_bus();
    t_w16();
    t_w13();
    t_reload();
    t_ext();
    t_gate();
    t_split();
    t_wr_wins();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule